// File: doc/BRIEF.md
# Cache Set/Way Maintenance Walker

This block sweeps a full 8-way set-associative cache one line at a time, addressing each line by its set and way. It does not touch the tag or data arrays. For every line position it emits one maintenance command on a valid/ready port. Each command carries a packed set/way operand and an operation code, either invalidate-only or clean-and-invalidate. Some other agent that owns the arrays and the writeback path carries out the command.

The size of the sweep is found at run time from a read-only cache type word. A 4-bit size field selects a way size of 8 KiB shifted left by the field value. With 32-byte lines, that gives 256 << field sets. The walker samples the type word and the operation select when a start is accepted, and it keeps them for the whole walk.

After the last command is accepted, the walker raises a barrier request and waits for its acknowledge. It then pulses done for one cycle. If the type word reports that no cache is present, a start finishes at once with a done pulse and issues no commands.

Top module: `setway_walker`

## Requirements
- R1: While reset is held, and in the first cycle after reset, cmd_valid_o, barrier_req_o, done_o and busy_o are all low.
- R2: One walk issues exactly 8 x (256 << F) accepted commands, where F is type_word_i[11:8] as sampled at start.
- R3: cmd_operand_o holds the way number in bits [31:29] and the set number in bits [28:5]. Bits [4:0] are zero.
- R4: Commands go in set-major order: ways 0 to 7 of set 0, then ways 0 to 7 of set 1, and so on up to the last set.
- R5: cmd_op_o is 0 for invalidate and 1 for clean-and-invalidate. It equals op_sel_i as sampled at start and is held for every command of the walk.
- R6: A command is accepted only in a cycle where cmd_valid_o and cmd_ready_i are both high. While ready is low, valid stays high and the operand is unchanged.
- R7: After the last command is accepted, barrier_req_o goes high in the next cycle and stays high until barrier_ack_i is seen. No command is valid in that time.
- R8: done_o is high for exactly one cycle, the cycle after barrier_ack_i is sampled with barrier_req_o high. busy_o is low from that cycle on.
- R9: When type_word_i[7:3] is all zero at start, done_o pulses in the next cycle. No command and no barrier request is issued.
- R10: A start asserted while busy_o is high has no effect on the walk in progress.
- R11: Changes to type_word_i and op_sel_i after start do not change the length or the operation code of the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a walk; taken only when idle |
| op_sel_i | input | 1 | 0 = invalidate, 1 = clean-and-invalidate |
| type_word_i | input | 32 | Read-only cache type word (size field [11:8], presence field [7:3]) |
| cmd_valid_o | output | 1 | A maintenance command is offered |
| cmd_ready_i | input | 1 | The maintenance port takes the offered command |
| cmd_operand_o | output | 32 | Packed set/way operand |
| cmd_op_o | output | 1 | Operation code of the offered command |
| barrier_req_o | output | 1 | Final barrier requested |
| barrier_ack_i | input | 1 | Final barrier completed |
| busy_o | output | 1 | A walk or its barrier is in progress |
| done_o | output | 1 | One-cycle pulse when the walk has completed |

## Verification
Walks are run at size codes 0, 1 and 2. This separates a correct run-time set count from a count fixed at one size, and the set field width is exercised beyond the low byte. The ready input is driven three ways: held high, toggling on alternate cycles, and following a pseudo-random pattern. These show that the walker advances only on real handshakes and holds the operand while stalled. The walks use both operation codes, and one walk has a start, a new size and a flipped operation applied mid-sweep to expose any resampling. The barrier is acknowledged after different delays, and a type word that reports no cache covers the path that completes at once.

// File: rtl/walk_pkg.sv
// Package: shared types for the set/way maintenance walker.
// Assumes: one walk at a time; operation codes are single bit.
package walk_pkg;

    // Controller states: idle, issuing commands, waiting for the final barrier
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_FENCE = 2'd2
    } walk_state_e;

    // Maintenance operation code carried on the command port
    typedef enum logic {
        OP_INVAL       = 1'b0,
        OP_CLEAN_INVAL = 1'b1
    } maint_op_e;

endpackage

// File: rtl/sw_type_decode.sv
// Module: sw_type_decode
// Decodes the cache type word into a presence flag and the index of the
// last set. The set count is 2^(BASE_WAY_LOG2 - LINE_SHIFT + size field).
// Assumes: a set count wider than SET_W is clamped to all ones.
module sw_type_decode #(
    parameter int WORD_W        = 32,
    parameter int SET_W         = 24,
    parameter int LINE_SHIFT    = 5,
    parameter int BASE_WAY_LOG2 = 13,
    parameter int SIZE_LSB      = 8,
    parameter int SIZE_W        = 4,
    parameter int PRES_LSB      = 3,
    parameter int PRES_W        = 5
) (
    input  logic [WORD_W-1:0] type_word_i,
    output logic              present_o,
    output logic [SET_W-1:0]  last_set_o
);
    localparam int SET_BASE_LOG2 = BASE_WAY_LOG2 - LINE_SHIFT;

    logic [SIZE_W-1:0] size_field;
    logic [PRES_W-1:0] pres_field;
    logic              unused_type_bits;

    assign size_field       = type_word_i[SIZE_LSB +: SIZE_W];
    assign pres_field       = type_word_i[PRES_LSB +: PRES_W];
    assign unused_type_bits = ^type_word_i;

    // Presence: any bit of the presence field set
    assign present_o = |pres_field;

    // Last set index: low (SET_BASE_LOG2 + size) bits set, clamped to SET_W
    always_comb begin
        int unsigned lg;
        lg = SET_BASE_LOG2 + int'(size_field);
        if (lg >= SET_W) begin
            last_set_o = '1;
        end else begin
            last_set_o = ~({SET_W{1'b1}} << lg);
        end
    end
endmodule

// File: rtl/sw_index_ctr.sv
// Module: sw_index_ctr
// Set-major set/way position counter. The way advances first; on a way wrap
// the set advances. The last set index is captured on load and held.
// Assumes: step is not applied while load is high; holds at the final position.
module sw_index_ctr #(
    parameter int SET_W = 24,
    parameter int WAY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [SET_W-1:0] last_set_i,
    output logic [SET_W-1:0] set_o,
    output logic [WAY_W-1:0] way_o,
    output logic             final_o
);
    localparam logic [WAY_W-1:0] WAY_MAX = '1;

    logic [SET_W-1:0] set_q;
    logic [WAY_W-1:0] way_q;
    logic [SET_W-1:0] last_q;

    // Final position: last way of the last captured set
    assign final_o = (way_q == WAY_MAX) && (set_q == last_q);
    assign set_o   = set_q;
    assign way_o   = way_q;

    // Position update: clear on load, advance way then set on step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q  <= '0;
            way_q  <= '0;
            last_q <= '0;
        end else if (load_i) begin
            set_q  <= '0;
            way_q  <= '0;
            last_q <= last_set_i;
        end else if (step_i && !final_o) begin
            if (way_q == WAY_MAX) begin
                way_q <= '0;
                set_q <= set_q + 1'b1;
            end else begin
                way_q <= way_q + 1'b1;
            end
        end
    end

    // R2: set index never passes the captured last set
    assert_set_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_q <= last_q);

    // R4: a way wrap moves to the next set at way 0
    assert_set_major_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !final_o && way_q == WAY_MAX)
            |=> (way_q == '0) && (set_q == $past(set_q) + 1'b1));

    // R6: without a step or load the position holds
    assert_pos_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(set_q) && $stable(way_q));
endmodule

// File: rtl/sw_operand_pack.sv
// Module: sw_operand_pack
// Packs the set/way position into the command operand: way in the top
// WAY_W bits, set just above the line offset, line offset bits zero.
// Assumes: WAY_W + SET_W + LINE_SHIFT equals WORD_W.
module sw_operand_pack #(
    parameter int WORD_W     = 32,
    parameter int SET_W      = 24,
    parameter int WAY_W      = 3,
    parameter int LINE_SHIFT = 5
) (
    input  logic [SET_W-1:0]  set_i,
    input  logic [WAY_W-1:0]  way_i,
    output logic [WORD_W-1:0] operand_o
);
    localparam int WAY_LSB = WORD_W - WAY_W;

    // Field placement: one generate branch per bit position
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (b >= WAY_LSB) begin : g_way
            assign operand_o[b] = way_i[b - WAY_LSB];
        end else if (b >= LINE_SHIFT) begin : g_set
            assign operand_o[b] = set_i[b - LINE_SHIFT];
        end else begin : g_off
            assign operand_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/sw_walk_ctrl.sv
// Module: sw_walk_ctrl
// Sequences one walk: accepts a start when idle, offers commands until the
// final position is accepted, requests the barrier, then pulses done.
// Assumes: present_i and final_i are valid in the cycle they are used.
module sw_walk_ctrl
    import walk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic present_i,
    input  logic op_sel_i,
    input  logic cmd_ready_i,
    input  logic final_i,
    input  logic fence_ack_i,
    output logic load_o,
    output logic step_o,
    output logic cmd_valid_o,
    output logic op_o,
    output logic fence_req_o,
    output logic done_o,
    output logic busy_o
);
    walk_state_e state_q;
    maint_op_e   op_q;
    logic        done_q;
    logic        accept;

    assign accept      = (state_q == ST_IDLE) && start_i;
    assign load_o      = accept && present_i;
    assign cmd_valid_o = (state_q == ST_WALK);
    assign step_o      = cmd_valid_o && cmd_ready_i;
    assign fence_req_o = (state_q == ST_FENCE);
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign op_o        = op_q;

    // State, latched operation and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_INVAL;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (present_i) begin
                            state_q <= ST_WALK;
                            op_q    <= maint_op_e'(op_sel_i);
                        end else begin
                            done_q  <= 1'b1;
                        end
                    end
                end
                ST_WALK: begin
                    if (step_o && final_i) begin
                        state_q <= ST_FENCE;
                    end
                end
                ST_FENCE: begin
                    if (fence_ack_i) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8: done lasts a single cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done only follows an acknowledged barrier or an absent-cache start
    assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(fence_req_o && fence_ack_i)
                       || $past(start_i && !busy_o && !present_i));

    // R7: barrier request holds until acknowledged
    assert_fence_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_req_o && !fence_ack_i) |=> fence_req_o);

    // R7: the last accepted command leads straight to the barrier
    assert_fence_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && final_i) |=> fence_req_o && !cmd_valid_o);

    // R10: a start while busy leaves the operation unchanged
    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(op_o));
endmodule

// File: rtl/setway_walker.sv
// Module: setway_walker (top)
// Walks every set and way of an 8-way cache, issuing one maintenance
// command per line on a valid/ready port, then a final barrier and a
// one-cycle done pulse. Type word and operation are sampled at start.
// Assumes: the command consumer keeps ready independent of the operand.
module setway_walker #(
    parameter int WORD_W        = 32,
    parameter int WAY_W         = 3,
    parameter int LINE_SHIFT    = 5,
    parameter int BASE_WAY_LOG2 = 13,
    parameter int SIZE_LSB      = 8,
    parameter int SIZE_W        = 4,
    parameter int PRES_LSB      = 3,
    parameter int PRES_W        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_sel_i,
    input  logic [WORD_W-1:0] type_word_i,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [WORD_W-1:0] cmd_operand_o,
    output logic              cmd_op_o,
    output logic              barrier_req_o,
    input  logic              barrier_ack_i,
    output logic              busy_o,
    output logic              done_o
);
    localparam int WAY_LSB = WORD_W - WAY_W;
    localparam int SET_W   = WAY_LSB - LINE_SHIFT;

    logic             present;
    logic [SET_W-1:0] last_set;
    logic [SET_W-1:0] set_idx;
    logic [WAY_W-1:0] way_idx;
    logic             at_final;
    logic             load;
    logic             step;

    sw_type_decode #(
        .WORD_W(WORD_W), .SET_W(SET_W), .LINE_SHIFT(LINE_SHIFT),
        .BASE_WAY_LOG2(BASE_WAY_LOG2), .SIZE_LSB(SIZE_LSB), .SIZE_W(SIZE_W),
        .PRES_LSB(PRES_LSB), .PRES_W(PRES_W)
    ) u_decode (
        .type_word_i(type_word_i),
        .present_o  (present),
        .last_set_o (last_set)
    );

    sw_walk_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .present_i  (present),
        .op_sel_i   (op_sel_i),
        .cmd_ready_i(cmd_ready_i),
        .final_i    (at_final),
        .fence_ack_i(barrier_ack_i),
        .load_o     (load),
        .step_o     (step),
        .cmd_valid_o(cmd_valid_o),
        .op_o       (cmd_op_o),
        .fence_req_o(barrier_req_o),
        .done_o     (done_o),
        .busy_o     (busy_o)
    );

    sw_index_ctr #(.SET_W(SET_W), .WAY_W(WAY_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (step),
        .last_set_i(last_set),
        .set_o     (set_idx),
        .way_o     (way_idx),
        .final_o   (at_final)
    );

    sw_operand_pack #(
        .WORD_W(WORD_W), .SET_W(SET_W), .WAY_W(WAY_W), .LINE_SHIFT(LINE_SHIFT)
    ) u_pack (
        .set_i    (set_idx),
        .way_i    (way_idx),
        .operand_o(cmd_operand_o)
    );

    // R6: a stalled command keeps valid and its operand
    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> cmd_valid_o && $stable(cmd_operand_o));

    // R5: operation code is constant across consecutive offered commands
    assert_op_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && $past(cmd_valid_o)) |-> $stable(cmd_op_o));

    // R4: an accepted non-wrapping command moves to the next way in the same set
    assert_way_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_ready_i && cmd_operand_o[WORD_W-1 -: WAY_W] != '1)
            |=> cmd_operand_o[WORD_W-1 -: WAY_W] == $past(cmd_operand_o[WORD_W-1 -: WAY_W]) + 1'b1
             && cmd_operand_o[WAY_LSB-1:0] == $past(cmd_operand_o[WAY_LSB-1:0]));

    // R7: command port and barrier request are never active together
    assert_port_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid_o && barrier_req_o));
endmodule

// File: tb/tb_setway_walker.sv
// Directed bench for setway_walker: one task per scenario, each checks itself.
module tb_setway_walker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic        op_sel_i;
    logic [31:0] type_word_i;
    logic        cmd_valid_o;
    logic        cmd_ready_i;
    logic [31:0] cmd_operand_o;
    logic        cmd_op_o;
    logic        barrier_req_o;
    logic        barrier_ack_i;
    logic        busy_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    setway_walker dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_sel_i(op_sel_i),
        .type_word_i(type_word_i), .cmd_valid_o(cmd_valid_o),
        .cmd_ready_i(cmd_ready_i), .cmd_operand_o(cmd_operand_o),
        .cmd_op_o(cmd_op_o), .barrier_req_o(barrier_req_o),
        .barrier_ack_i(barrier_ack_i), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] present_word(input int sz);
        return 32'hA000_0040 | (32'(sz & 15) << 8);
    endfunction

    // R1: outputs quiet during and right after reset
    task automatic t_reset();
        rst_n = 1'b0; start_i = 0; op_sel_i = 0; cmd_ready_i = 0;
        barrier_ack_i = 0; type_word_i = 32'h0;
        repeat (3) @(negedge clk);
        chk(!cmd_valid_o && !barrier_req_o, "R1 in reset valid/barrier", {cmd_valid_o, barrier_req_o}, 0);
        chk(!done_o && !busy_o, "R1 in reset done/busy", {done_o, busy_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_valid_o && !barrier_req_o && !done_o && !busy_o,
            "R1 after reset", {cmd_valid_o, barrier_req_o, done_o, busy_o}, 0);
    endtask

    // R2 R3 R4 R5 R6 R7 R8 R10 R11: one full walk with a chosen ready pattern
    task automatic t_walk(input int sz, input bit op, input int rdy_mode,
                          input int ack_wait, input bit disturb);
        int exp_set = 0;
        int exp_way = 0;
        int ncmd = 0;
        int cyc = 0;
        int total = 8 << (8 + sz);
        int last = (256 << sz) - 1;
        bit order_ok = 1, op_ok = 1, valid_ok = 1, early_ok = 1, hold_ok = 1;
        logic [31:0] bad_act = 0, bad_exp = 0;
        logic [7:0] lfsr = 8'h5A;
        bit r;
        @(negedge clk);
        type_word_i = present_word(sz);
        op_sel_i = op;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (ncmd < total && cyc < 60000) begin
            logic [31:0] expv;
            expv = (32'(exp_way) << 29) | (32'(exp_set) << 5);
            if (!cmd_valid_o) valid_ok = 0;
            if (done_o || barrier_req_o) early_ok = 0;
            if (cmd_operand_o !== expv && order_ok) begin
                order_ok = 0; bad_act = cmd_operand_o; bad_exp = expv;
            end
            if (cmd_op_o !== op) op_ok = 0;
            case (rdy_mode)
                0: r = 1'b1;
                1: r = cyc[0];
                default: begin
                    r = lfsr[0] | lfsr[2];
                    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                end
            endcase
            cmd_ready_i = r;
            if (disturb && cyc == 10) begin
                start_i = 1'b1;
                type_word_i = present_word(sz + 1);
                op_sel_i = ~op;
            end
            @(negedge clk);
            start_i = 1'b0;
            if (cmd_valid_o && !r && (exp_way != 0 || exp_set != 0) && ncmd < total) begin
                if (cmd_operand_o !== expv) hold_ok = 0;
            end
            if (r) begin
                ncmd++;
                if (exp_way == 7) begin exp_way = 0; exp_set++; end
                else exp_way++;
            end
            cyc++;
        end
        cmd_ready_i = 1'b0;
        chk(ncmd == total, "R2 command count", ncmd, total);
        chk(exp_set == last + 1, "R2 sets covered", exp_set, last + 1);
        chk(order_ok, "R3 R4 operand order", bad_act, bad_exp);
        chk(op_ok, "R5 op code held", cmd_op_o, op);
        chk(valid_ok && hold_ok, "R6 valid and operand held under stall", {valid_ok, hold_ok}, 2'b11);
        chk(early_ok, "R7 no barrier or done during walk", early_ok, 1);
        if (disturb) chk(ncmd == total && op_ok, "R10 R11 mid-walk start ignored", ncmd, total);
        chk(barrier_req_o && !cmd_valid_o, "R7 barrier after last command",
            {barrier_req_o, cmd_valid_o}, 2'b10);
        begin
            bit held = 1;
            for (int i = 0; i < ack_wait; i++) begin
                @(negedge clk);
                if (!barrier_req_o || cmd_valid_o || done_o) held = 0;
            end
            chk(held, "R7 barrier held until ack", held, 1);
        end
        barrier_ack_i = 1'b1;
        @(negedge clk);
        barrier_ack_i = 1'b0;
        chk(done_o && !barrier_req_o && !busy_o, "R8 done after ack",
            {done_o, barrier_req_o, busy_o}, 3'b100);
        @(negedge clk);
        chk(!done_o, "R8 done single cycle", done_o, 0);
    endtask

    // R9: absent cache completes at once with no commands
    task automatic t_absent();
        bit quiet = 1;
        @(negedge clk);
        type_word_i = 32'h0000_0307;
        op_sel_i = 1'b1;
        cmd_ready_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o && !cmd_valid_o && !barrier_req_o, "R9 immediate done",
            {done_o, cmd_valid_o, barrier_req_o}, 3'b100);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (done_o || cmd_valid_o || barrier_req_o || busy_o) quiet = 0;
        end
        chk(quiet, "R9 no commands or barrier", quiet, 1);
        cmd_ready_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_walk(0, 1'b0, 0, 0, 1'b0);
        t_walk(0, 1'b1, 1, 3, 1'b0);
        t_absent();
        t_walk(1, 1'b1, 2, 1, 1'b0);
        t_walk(2, 1'b0, 0, 5, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule